// File: doc/BRIEF.md
# Tri-State Pin Charge-Mode Arbiter

This block picks the input current limit mode of a battery charger. Two sources compete for control: the result of cable-source detection on the USB data lines, and a three-level configuration pin whose level has already been decoded into low, floating or high. After input power turns valid, the block records the pin level once. It then waits for source detection to finish and applies the mode that detection implies.

The detected mode stays in force until the pin moves away from the level recorded at power-up and keeps the new level for longer than a deglitch window. From then on the pin owns the mode directly. Detection completes a fixed time after a pull-up is seen on a data line, or after a longer fixed time with no pull-up, whichever comes first. Every delay is a parameter counted in clock cycles.

The mode code only selects a limit. Enforcing the resistor-programmed limit as the ceiling for every mode is left to the downstream regulation loop.

Top module: `chg_mode_arbiter`

## Requirements
- R1: While `pwr_ok` is low, `mode` is 00 and `pin_ctrl` is 0. A power drop clears the recorded level, the detection result and the pin ownership, so the next power-up starts over.
- R2: The mode code is 00 for 100 mA, 01 for 500 mA and 10 for the resistor-programmed limit. Code 11 never appears.
- R3: From power-up until detection completes, `mode` is 00 and `pin_ctrl` is 0.
- R4: With no pull-up, detection completes on the clock edge at which the power-up cycle count equals `NOPULL_DLY`. The detected mode is then 00.
- R5: After a `pullup_seen` pulse, detection completes `PULLUP_DLY` + 1 cycles later. If `dedicated` is high at that moment the mode becomes 10, otherwise it becomes 00.
- R6: The pin level (00 low, 01 floating, 10 high) is recorded on the edge at which the power-up count equals `SAMPLE_DLY`.
- R7: Once detection is complete, the pin takes control (`pin_ctrl` rises) only after its level has differed from the recorded one for `DEGLITCH` + 1 consecutive clock edges. A shorter excursion restarts the count and leaves the mode unchanged.
- R8: Any pin excursion that occurs before detection completes has no effect.
- R9: After the pin takes control, `mode` follows the live pin level with no delay: low gives 10, floating gives 00, high gives 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Input supply is above its undervoltage threshold |
| pullup_seen | input | 1 | Pulse: a pull-up was detected on a data line |
| dedicated | input | 1 | Detected source is a dedicated charger (valid when detection completes) |
| pin_lvl | input | 2 | Decoded pin level: 00 low, 01 floating, 10 high |
| mode | output | 2 | Current limit mode code |
| pin_ctrl | output | 1 | The pin owns the mode |

## Verification
The assertions assume that `pin_lvl` never carries the unused code 11 and that `dedicated` is stable by the time detection completes. The stimulus drives only the three legal pin codes and holds `dedicated` at a constant level for each power cycle. Inputs change only on falling edges, so every pin excursion covers a whole number of rising edges. Short excursions are kept at exactly `DEGLITCH` edges, so the deglitch boundary is tested on both sides.

// File: rtl/chg_mode_arbiter.sv
module chg_mode_arbiter #(
  parameter int SAMPLE_DLY = 532,
  parameter int PULLUP_DLY = 100000,
  parameter int NOPULL_DLY = 570000,
  parameter int DEGLITCH   = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_ok,
  input  logic       pullup_seen,
  input  logic       dedicated,
  input  logic [1:0] pin_lvl,
  output logic [1:0] mode,
  output logic       pin_ctrl
);
  localparam int TW = $clog2(NOPULL_DLY + 1);
  localparam int PW = $clog2(PULLUP_DLY + 1);
  localparam int GW = $clog2(DEGLITCH + 1);
  localparam logic [1:0] M_100 = 2'b00, M_500 = 2'b01, M_RES = 2'b10;
  localparam logic [1:0] LVL_LOW = 2'b00, LVL_HIGH = 2'b10;

  logic [TW-1:0] t_cnt;
  logic [PW-1:0] pu_cnt;
  logic [GW-1:0] g_cnt;
  logic          pu_seen, samp_vld, det_done, det_res, released;
  logic [1:0]    samp_lvl;
  logic [1:0]    pin_mode;

  wire mismatch = pin_lvl != samp_lvl;
  wire done_now = samp_vld && !det_done &&
                  ((t_cnt == TW'(NOPULL_DLY)) || (pu_seen && pu_cnt == PW'(PULLUP_DLY)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_cnt <= '0; pu_cnt <= '0; g_cnt <= '0;
      pu_seen <= 1'b0; samp_vld <= 1'b0; samp_lvl <= 2'b01;
      det_done <= 1'b0; det_res <= 1'b0; released <= 1'b0;
    end else if (!pwr_ok) begin
      t_cnt <= '0; pu_cnt <= '0; g_cnt <= '0;
      pu_seen <= 1'b0; samp_vld <= 1'b0; samp_lvl <= 2'b01;
      det_done <= 1'b0; det_res <= 1'b0; released <= 1'b0;
    end else begin
      if (t_cnt != TW'(NOPULL_DLY)) t_cnt <= t_cnt + 1'b1;
      if (t_cnt == TW'(SAMPLE_DLY) && !samp_vld) begin
        samp_lvl <= pin_lvl;
        samp_vld <= 1'b1;
      end
      if (pullup_seen && !det_done) pu_seen <= 1'b1;
      if (pu_seen && !det_done && pu_cnt != PW'(PULLUP_DLY)) pu_cnt <= pu_cnt + 1'b1;
      if (done_now) begin
        det_done <= 1'b1;
        det_res  <= pu_seen && dedicated;
      end
      if (det_done && !released) begin
        if (mismatch) begin
          if (g_cnt == GW'(DEGLITCH)) released <= 1'b1;
          else g_cnt <= g_cnt + 1'b1;
        end else begin
          g_cnt <= '0;
        end
      end
    end
  end

  always_comb begin
    case (pin_lvl)
      LVL_LOW:  pin_mode = M_RES;
      LVL_HIGH: pin_mode = M_500;
      default:  pin_mode = M_100;
    endcase
  end

  assign mode     = !pwr_ok ? M_100 :
                    released ? pin_mode :
                    (det_done && det_res) ? M_RES : M_100;
  assign pin_ctrl = pwr_ok && released;
endmodule

// File: rtl/chg_mode_arbiter_chk.sv
module chg_mode_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_ok,
  input logic [1:0] pin_lvl,
  input logic [1:0] mode,
  input logic       pin_ctrl,
  input logic       det_done,
  input logic [1:0] samp_lvl
);
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> !pin_ctrl);

  p_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11);

  p_early_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !det_done |-> mode == 2'b00 && !pin_ctrl);

  p_deglitch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_ctrl) |-> $past(pin_lvl) != samp_lvl);

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pin_ctrl && pwr_ok |=> pin_ctrl || !pwr_ok);

  p_needs_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pin_ctrl |-> det_done);
endmodule

bind chg_mode_arbiter chg_mode_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .pin_lvl(pin_lvl),
  .mode(mode), .pin_ctrl(pin_ctrl), .det_done(det_done), .samp_lvl(samp_lvl)
);

// File: tb/chg_mode_arbiter_tb_top.sv
`timescale 1ns/1ps
module chg_mode_arbiter_tb_top;
  localparam int S = 5, P = 20, N = 60, D = 4;

  logic clk = 1'b0, rst_n = 1'b0, pwr_ok = 1'b0, pullup_seen = 1'b0, dedicated = 1'b0;
  logic [1:0] pin_lvl = 2'b01;
  logic [1:0] mode;
  logic pin_ctrl;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  typedef struct { logic [1:0] m; logic c; string tag; } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  chg_mode_arbiter #(.SAMPLE_DLY(S), .PULLUP_DLY(P), .NOPULL_DLY(N), .DEGLITCH(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .pullup_seen(pullup_seen),
    .dedicated(dedicated), .pin_lvl(pin_lvl), .mode(mode), .pin_ctrl(pin_ctrl));

  task automatic expect_out(input logic [1:0] m, input logic c, input string tag);
    exp_t e;
    e.m = m; e.c = c; e.tag = tag;
    q.push_back(e);
    wait (q.size() == 0);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    forever begin
      exp_t e;
      wait (q.size() > 0);
      #1;
      e = q[0];
      checks++;
      if (mode !== e.m || pin_ctrl !== e.c) begin
        errors++;
        $display("FAIL %s: mode=%b ctrl=%b expected mode=%b ctrl=%b", e.tag, mode, pin_ctrl, e.m, e.c);
      end
      void'(q.pop_front());
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    expect_out(2'b00, 1'b0, "R1 reset idle");

    // no pull-up, pin high recorded
    pin_lvl = 2'b10;
    pwr_ok = 1'b1;
    cyc(30);
    expect_out(2'b00, 1'b0, "R3 before detection done");
    cyc(32);
    expect_out(2'b00, 1'b0, "R4 no pull-up gives 100mA");
    pin_lvl = 2'b00;
    cyc(D);
    expect_out(2'b00, 1'b0, "R7 short excursion ignored");
    pin_lvl = 2'b10;
    cyc(1);
    expect_out(2'b00, 1'b0, "R6 recorded level high matches");
    pin_lvl = 2'b00;
    cyc(D);
    expect_out(2'b00, 1'b0, "R7 count restarted");
    cyc(1);
    expect_out(2'b10, 1'b1, "R7 release after DEGLITCH+1");
    expect_out(2'b10, 1'b1, "R9 low gives resistor mode");
    pin_lvl = 2'b01;
    expect_out(2'b00, 1'b0 | 1'b1, "R9 floating gives 100mA");
    pin_lvl = 2'b10;
    expect_out(2'b01, 1'b1, "R9 high gives 500mA");
    expect_out(2'b01, 1'b1, "R2 500mA code");

    pwr_ok = 1'b0;
    expect_out(2'b00, 1'b0, "R1 power drop");
    cyc(3);

    // dedicated charger, pin floating recorded
    pin_lvl = 2'b01;
    dedicated = 1'b1;
    pwr_ok = 1'b1;
    cyc(10);
    pullup_seen = 1'b1;
    cyc(1);
    pullup_seen = 1'b0;
    cyc(4);
    pin_lvl = 2'b10;
    cyc(10);
    expect_out(2'b00, 1'b0, "R8 excursion before done ignored");
    pin_lvl = 2'b01;
    cyc(9);
    expect_out(2'b10, 1'b0, "R5 dedicated gives resistor mode");
    cyc(10);
    expect_out(2'b10, 1'b0, "R8 no release after early excursion");
    pin_lvl = 2'b10;
    cyc(D + 1);
    expect_out(2'b01, 1'b1, "R9 release to high");

    pwr_ok = 1'b0;
    cyc(3);
    expect_out(2'b00, 1'b0, "R1 idle while off");

    // host with pull-up, pin high recorded
    dedicated = 1'b0;
    pin_lvl = 2'b10;
    pwr_ok = 1'b1;
    cyc(10);
    pullup_seen = 1'b1;
    cyc(1);
    pullup_seen = 1'b0;
    cyc(9);
    expect_out(2'b00, 1'b0, "R1 ownership cleared by power drop");
    cyc(14);
    expect_out(2'b00, 1'b0, "R5 host gives 100mA");
    pin_lvl = 2'b00;
    cyc(D + 1);
    expect_out(2'b10, 1'b1, "R7 release on host path");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule